// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block moves bytes between system memory and a keyed configuration item store without the host touching the item data one byte at a time. Software places a 16-byte descriptor in memory and writes its physical address into a 64-bit pointer register. The engine then fetches the descriptor through a byte-wide memory master port. The descriptor holds a control word, a length and a buffer address, each stored with its most significant byte first. The engine may first switch to a new item key. It then reads from the item, writes into the item or skips forward in the item, and finally rewrites the control word in memory to report the result.

The item store sits behind a simple byte interface. The engine presents the current key and byte offset. The store answers with the item length, a read-only flag and the byte at that offset, and it accepts single-byte writes at the current offset. Memory requests are held until granted. A read request returns its byte on a separate valid strobe.

Top module: `cfg_dma_engine`

## Requirements
- R1: A pointer write with `ptr_wr_full` set loads all 64 bits and starts an operation. A 32-bit write with `ptr_wr_low` clear loads pointer bits 63:32 only and starts nothing. A 32-bit write with `ptr_wr_low` set loads bits 31:0 and starts an operation on the combined pointer.
- R2: `ptr_rd_data` always returns 0x51454d5520434647.
- R3: The descriptor is fetched as 16 bytes from pointer+0 upward. Bytes 0-3 form the control word, bytes 4-7 the length and bytes 8-15 the buffer address, each most significant byte first.
- R4: When control bit 3 is set, the key becomes control bits 31:16 and the offset becomes 0. Otherwise the key and offset carry over from the previous operation. After reset the key is 0 and the offset is 0.
- R5: Control bit 1 (read) takes priority over bits 4 and 2. In a read, length bytes from the item at the current offset are written to the buffer address upward.
- R6: Read bytes beyond the item end are written as zero, and the offset stops at the item length.
- R7: With bit 4 set and bit 1 clear, length bytes are copied from the buffer into the item at the current offset, and the offset advances by length.
- R8: A write whose offset+length exceeds the item length, or whose target item is read-only, changes no item byte and leaves the offset unchanged. It reports an error.
- R9: With bit 2 set and bits 1 and 4 clear, the offset advances by length, clamped to the item length. No memory data is moved.
- R10: On completion the control word at pointer+0 is rewritten as 0x00000000 on success or 0x00000001 on error, most significant byte first. A descriptor with no operation bit set completes with success.
- R11: `busy` rises on an accepted start and falls once the last writeback byte is granted. All pointer writes while busy are ignored. No memory or item access happens while idle.
- R12: A memory request keeps its address, direction and write data unchanged until it is granted.
- R13: A length of zero moves no data and still writes back the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_valid | input | 1 | Pointer register write strobe |
| ptr_wr_full | input | 1 | Write carries all 64 bits |
| ptr_wr_low | input | 1 | For a 32-bit write: 1 = low half, 0 = high half |
| ptr_wr_data | input | 64 | Write data (32-bit writes use bits 31:0) |
| ptr_rd_data | output | 64 | Pointer register read value (fixed signature) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read byte valid |
| mem_rdata | input | 8 | Read byte |
| item_key | output | KW | Currently selected item key |
| item_off | output | LW | Current byte offset in the item |
| item_len | input | LW | Length of the selected item |
| item_ro | input | 1 | Selected item is read-only |
| item_rd_data | input | 8 | Item byte at `item_off` |
| item_wr_en | output | 1 | Write `item_wr_data` at `item_off` |
| item_wr_data | output | 8 | Item write byte |

## Verification
Several rules are checked by the assertions on every cycle. Memory requests stay stable until granted. Nothing touches memory or the item store while idle. Every item write lands inside the item and never hits a read-only item. The offset never passes the item end. Busy only rises after a pointer write. The bench scenarios are needed for the rest. These cover the read/write/skip priority, big-endian descriptor decoding, zero fill past the item end, the all-or-nothing rejection of oversized or read-only writes, the clamped skip, the split-pointer trigger, and the pointer writes ignored while busy. These can only be seen by comparing memory and item contents against expected values after whole operations, with grants stalled every other cycle.

// File: rtl/cfg_dma_engine.sv
`timescale 1ns/1ps
module cfg_dma_engine #(
  parameter int KW = 16,
  parameter int LW = 32,
  parameter logic [63:0] SIGNATURE = 64'h51454d5520434647
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr_valid,
  input  logic          ptr_wr_full,
  input  logic          ptr_wr_low,
  input  logic [63:0]   ptr_wr_data,
  output logic [63:0]   ptr_rd_data,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [63:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  output logic [KW-1:0] item_key,
  output logic [LW-1:0] item_off,
  input  logic [LW-1:0] item_len,
  input  logic          item_ro,
  input  logic [7:0]    item_rd_data,
  output logic          item_wr_en,
  output logic [7:0]    item_wr_data
);

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_SEL, S_OP, S_RD, S_WREQ, S_WWAIT, S_WB
  } st_t;

  st_t           st;
  logic [63:0]   ptr;
  logic [127:0]  desc;
  logic [3:0]    cnt;
  logic [LW-1:0] rem, xcnt;
  logic          err;

  logic [31:0]   ctl;
  logic [LW-1:0] len;
  logic [63:0]   baddr;
  assign ctl   = desc[127:96];
  assign len   = desc[64 +: LW];
  assign baddr = desc[63:0];

  logic [LW:0]   off_sum;
  logic [LW-1:0] off_clamp;
  logic          wr_bad, past_end;
  assign off_sum   = {1'b0, item_off} + {1'b0, len};
  assign off_clamp = (off_sum > {1'b0, item_len}) ? item_len : off_sum[LW-1:0];
  assign wr_bad    = item_ro || (off_sum > {1'b0, item_len});
  assign past_end  = item_off >= item_len;

  assign ptr_rd_data  = SIGNATURE;
  assign busy         = st != S_IDLE;
  assign item_wr_en   = (st == S_WWAIT) && mem_rvalid;
  assign item_wr_data = mem_rdata;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = ptr + 64'(cnt);
      end
      S_RD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = baddr + 64'(xcnt);
        mem_wdata = past_end ? 8'h00 : item_rd_data;
      end
      S_WREQ: begin
        mem_req  = 1'b1;
        mem_addr = baddr + 64'(xcnt);
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + 64'(cnt);
        mem_wdata = (cnt == 4'd3) ? {7'b0, err} : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      desc     <= '0;
      cnt      <= '0;
      rem      <= '0;
      xcnt     <= '0;
      err      <= 1'b0;
      item_key <= '0;
      item_off <= '0;
    end else begin
      case (st)
        S_IDLE: if (ptr_wr_valid) begin
          if (ptr_wr_full) begin
            ptr <= ptr_wr_data;
            st  <= S_FREQ;
          end else if (!ptr_wr_low) begin
            ptr[63:32] <= ptr_wr_data[31:0];
          end else begin
            ptr[31:0] <= ptr_wr_data[31:0];
            st        <= S_FREQ;
          end
          cnt <= '0;
          err <= 1'b0;
        end
        S_FREQ: if (mem_gnt) st <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          desc <= {desc[119:0], mem_rdata};
          cnt  <= cnt + 4'd1;
          st   <= (cnt == 4'd15) ? S_SEL : S_FREQ;
        end
        S_SEL: begin
          if (ctl[3]) begin
            item_key <= ctl[31:16];
            item_off <= '0;
          end
          cnt  <= '0;
          xcnt <= '0;
          rem  <= len;
          st   <= S_OP;
        end
        S_OP: begin
          if (ctl[1]) begin
            st <= (rem == '0) ? S_WB : S_RD;
          end else if (ctl[4]) begin
            if (wr_bad) begin
              err <= 1'b1;
              st  <= S_WB;
            end else begin
              st <= (rem == '0) ? S_WB : S_WREQ;
            end
          end else if (ctl[2]) begin
            item_off <= off_clamp;
            st       <= S_WB;
          end else begin
            st <= S_WB;
          end
        end
        S_RD: if (mem_gnt) begin
          if (!past_end) item_off <= item_off + 1'b1;
          xcnt <= xcnt + 1'b1;
          rem  <= rem - 1'b1;
          if (rem == LW'(1)) st <= S_WB;
        end
        S_WREQ: if (mem_gnt) st <= S_WWAIT;
        S_WWAIT: if (mem_rvalid) begin
          item_off <= item_off + 1'b1;
          xcnt     <= xcnt + 1'b1;
          rem      <= rem - 1'b1;
          st       <= (rem == LW'(1)) ? S_WB : S_WREQ;
        end
        S_WB: if (mem_gnt) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd3) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_dma_engine_chk.sv
`timescale 1ns/1ps
module cfg_dma_engine_chk #(
  parameter int KW = 16,
  parameter int LW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_wr_valid,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [63:0]   mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_gnt,
  input logic [LW-1:0] item_off,
  input logic [LW-1:0] item_len,
  input logic          item_ro,
  input logic          item_wr_en
);

  a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r11_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r11_idle_no_item_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !item_wr_en);

  a_r11_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ptr_wr_valid));

  a_r8_write_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    item_wr_en |-> !item_ro && (item_off < item_len));

  a_r6_off_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    item_off <= item_len);

endmodule

bind cfg_dma_engine cfg_dma_engine_chk #(.KW(KW), .LW(LW)) u_chk (.*);

// File: tb/test_cfg_dma_engine.sv
`timescale 1ns/1ps
module test_cfg_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr_valid = 1'b0, ptr_wr_full = 1'b0, ptr_wr_low = 1'b0;
  logic [63:0] ptr_wr_data = '0;
  logic [63:0] ptr_rd_data;
  logic        busy;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] item_key;
  logic [31:0] item_off, item_len;
  logic        item_ro, item_wr_en;
  logic [7:0]  item_rd_data, item_wr_data;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfg_dma_engine i_cfg_dma_engine (.*);

  // memory and item store models
  logic [7:0] mem [256];
  logic [7:0] itm [4][8];
  logic       gtog;
  logic       poke_en = 1'b0;
  logic [7:0] poke_addr = '0, poke_data = '0;

  function automatic int idx_of(input logic [15:0] k);
    case (k)
      16'h0000: return 0;
      16'h0021: return 1;
      16'h0030: return 2;
      default:  return 3;
    endcase
  endfunction

  int cur;
  assign cur          = idx_of(item_key);
  assign item_len     = (cur == 0) ? 32'd4 : (cur == 1) ? 32'd8 : (cur == 2) ? 32'd6 : 32'd0;
  assign item_ro      = (cur == 0) || (cur == 2);
  assign item_rd_data = itm[cur][item_off[2:0]];
  assign mem_gnt      = mem_req && gtog;

  always @(posedge clk) begin
    if (!rst_n) begin
      gtog       <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      for (int a = 0; a < 256; a++) mem[a] <= 8'hEE;
      for (int i = 0; i < 8; i++) begin
        mem[8'h60 + i] <= 8'hC0 + 8'(i);
        mem[8'h68 + i] <= 8'hD0 + 8'(i);
        itm[1][i] <= 8'(i * 8'h11);
        itm[3][i] <= 8'h00;
      end
      itm[0][0] <= 8'h51; itm[0][1] <= 8'h45; itm[0][2] <= 8'h4d; itm[0][3] <= 8'h55;
      for (int i = 0; i < 6; i++) itm[2][i] <= 8'hA0 + 8'(i);
    end else begin
      gtog       <= ~gtog;
      mem_rvalid <= 1'b0;
      if (mem_gnt && !mem_we) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[7:0]];
      end
      if (mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (item_wr_en) itm[cur][item_off[2:0]] <= item_wr_data;
      if (poke_en) mem[poke_addr] <= poke_data;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic put_desc(input logic [7:0] at, input logic [31:0] c,
                          input logic [31:0] l, input logic [7:0] ba);
    logic [127:0] d;
    d = {c, l, 56'h0, ba};
    for (int i = 0; i < 16; i++) poke(at + 8'(i), d[127 - 8*i -: 8]);
  endtask

  task automatic ptr_write(input logic full, input logic low, input logic [63:0] d);
    @(negedge clk);
    ptr_wr_valid = 1'b1; ptr_wr_full = full; ptr_wr_low = low; ptr_wr_data = d;
    @(negedge clk);
    ptr_wr_valid = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (busy) begin
      checks++; fails++;
      $display("FAIL %s watchdog: busy stuck actual=1 expected=0", tag);
    end
  endtask

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] len;
    logic [7:0]  baddr;
    logic [31:0] exp_ctrl;
    logic [31:0] exp_off;
    logic [1:0]  pk;     // 0 none, 1 memory byte, 2 item 0x0021 byte, 3 item 0x0030 byte
    logic [7:0]  ploc;
    logic [7:0]  pval;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_000A, 32'd4,  8'h40, 32'd0, 32'd4, 2'd1, 8'h43, 8'h55},
    '{32'h0021_0008, 32'd0,  8'h00, 32'd0, 32'd0, 2'd0, 8'h00, 8'h00},
    '{32'h0000_0004, 32'd3,  8'h00, 32'd0, 32'd3, 2'd0, 8'h00, 8'h00},
    '{32'h0000_0004, 32'd10, 8'h00, 32'd0, 32'd8, 2'd0, 8'h00, 8'h00},
    '{32'h0021_000C, 32'd2,  8'h00, 32'd0, 32'd2, 2'd0, 8'h00, 8'h00},
    '{32'h0000_0010, 32'd4,  8'h60, 32'd0, 32'd6, 2'd2, 8'h05, 8'hC3},
    '{32'h0000_0010, 32'd3,  8'h60, 32'd1, 32'd6, 2'd2, 8'h06, 8'h66},
    '{32'h0030_0018, 32'd1,  8'h60, 32'd1, 32'd0, 2'd3, 8'h00, 8'hA0},
    '{32'h0000_0016, 32'd2,  8'h70, 32'd0, 32'd2, 2'd1, 8'h71, 8'hA1},
    '{32'h0000_0000, 32'd5,  8'h70, 32'd0, 32'd2, 2'd0, 8'h00, 8'h00},
    '{32'h0021_0018, 32'd8,  8'h68, 32'd0, 32'd8, 2'd2, 8'h07, 8'hD7},
    '{32'h0030_000A, 32'd8,  8'h80, 32'd0, 32'd6, 2'd1, 8'h86, 8'h00},
    '{32'h0000_0001, 32'd0,  8'h00, 32'd0, 32'd6, 2'd1, 8'h85, 8'hA5}
  };
  localparam string TAG [NV] = '{
    "R5 R3 read item 0x0000",
    "R4 R13 select only, zero length",
    "R9 skip",
    "R9 R6 skip clamped at item end",
    "R4 R9 select then skip",
    "R7 R12 write into item",
    "R8 oversize write rejected",
    "R8 read-only write rejected",
    "R5 read wins over write and skip",
    "R10 no operation bits",
    "R7 full-item write",
    "R6 read past end zero-filled",
    "R10 incoming error bit ignored"
  };

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: run exceeded limit actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R11 reset busy", 64'(busy), 64'd0);
    check("R11 reset mem_req", 64'(mem_req), 64'd0);
    check("R4 reset key", 64'(item_key), 64'd0);
    check("R4 reset offset", 64'(item_off), 64'd0);
    check("R2 signature read", ptr_rd_data, 64'h51454d5520434647);

    for (int v = 0; v < NV; v++) begin
      put_desc(8'h10, VEC[v].ctrl, VEC[v].len, VEC[v].baddr);
      ptr_write(1'b1, 1'b0, 64'h10);
      wait_idle(TAG[v]);
      check({TAG[v], " (R10 writeback)"},
            64'({mem[8'h10], mem[8'h11], mem[8'h12], mem[8'h13]}), 64'(VEC[v].exp_ctrl));
      check({TAG[v], " (offset)"}, 64'(item_off), 64'(VEC[v].exp_off));
      if (VEC[v].pk != 2'd0) begin
        case (VEC[v].pk)
          2'd1:    pb = mem[VEC[v].ploc];
          2'd2:    pb = itm[1][VEC[v].ploc[2:0]];
          default: pb = itm[2][VEC[v].ploc[2:0]];
        endcase
        check({TAG[v], " (data)"}, 64'(pb), 64'(VEC[v].pval));
      end
    end

    // R1 split pointer and R11 writes ignored while busy
    put_desc(8'h20, 32'h0021_000A, 32'd1, 8'h90);
    put_desc(8'h30, 32'h0000_0002, 32'd0, 8'h00);
    ptr_write(1'b0, 1'b0, 64'h0);
    check("R1 high-half write does not start", 64'(busy), 64'd0);
    ptr_write(1'b0, 1'b1, 64'h20);
    check("R11 low-half write starts", 64'(busy), 64'd1);
    ptr_write(1'b1, 1'b0, 64'h30);
    wait_idle("R1 split pointer");
    check("R1 split pointer read byte", 64'(mem[8'h90]), 64'hD0);
    check("R1 R10 split pointer writeback", 64'(mem[8'h23]), 64'h00);
    check("R11 write while busy ignored", 64'(mem[8'h33]), 64'h02);
    check("R11 idle after run", 64'(busy), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule